// File: doc/BRIEF.md
# Half-Duplex Carrier Sense and Collision Signalling

This block drives the carrier-sense (`crs`) and collision (`col`) outputs of a 10/100 Mb/s PHY's media-independent interface. Its inputs are internal activity flags: transmit active, receive active, a 10 Mb/s squelch-valid flag, and at 100 Mb/s a signal-detect flag plus the serial line bit. A single-cycle `bit_tick` strobe marks each bit time. Speed, duplex and heartbeat enable are plain static controls.

Receive carrier is recognised differently at each speed. At 10 Mb/s it follows squelch. At 100 Mb/s it needs signal detect and two non-adjacent zero bits on the line. In half duplex, `crs` covers transmit and receive. In full duplex it covers receive only.

A collision is transmit and receive carrier present together in half duplex. If a receive was already under way, or the speed is 100 Mb/s, the collision is reported at once. If the block was transmitting first at 10 Mb/s, the collision must last seven bit times before it is reported. At 10 Mb/s with heartbeat enabled, a signal-quality-error pulse is placed on `col` after each transmission ends.

No data flows through this block. All pins are plain level signals with no valid/ready handshake and no back-pressure.

Top module: `mii_carrier_col`

## Requirements
- R1: In half duplex (`full_dup`=0), `crs` is high one clock after a sampled cycle with `tx_act`=1 or receive carrier present, and low one clock after a cycle with neither.
- R2: In full duplex (`full_dup`=1), `crs` follows receive carrier only, one clock late. `tx_act` has no effect on it.
- R3: At 10 Mb/s (`speed_100`=0), receive carrier is `rx_act` AND `sq_valid`. `crs` drops one clock after either input falls, which marks the end of the packet.
- R4: At 100 Mb/s, receive carrier needs `sig_det`=1, `rx_act`=1 and a lock. The lock forms when `line_bit`, sampled on `bit_tick` cycles, shows a 0, then at least one 1, then a 0. Adjacent zeros do not lock. Dropping `sig_det` or `rx_act` clears the lock. `crs` follows two clocks after the locking tick.
- R5: In full duplex `col` is never high, even when transmit and receive carrier coincide.
- R6: A collision is reported immediately, with `col` high one clock after the onset, in two cases: receive carrier was present in the cycle before the onset, or the speed is 100 Mb/s.
- R7: A 10 Mb/s collision that starts without prior receive carrier is qualified. `col` rises one clock after the edge that samples the 7th `bit_tick` of the collision, counting from the onset cycle.
- R8: The qualification count restarts from zero whenever the collision condition drops before `col` has asserted.
- R9: Once `col` is high for a collision, it stays high while the condition lasts and falls one clock after the condition ends.
- R10: At 10 Mb/s, in half duplex with `hb_en`=1, the falling of `tx_act` arms a heartbeat. `col` goes high after the 10th following `bit_tick` and falls after the 20th.
- R11: The heartbeat is cancelled when `tx_act` rises during its 10-tick delay. It is suppressed at 100 Mb/s, in full duplex, or with `hb_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex |
| hb_en | input | 1 | Heartbeat enable |
| tx_act | input | 1 | Transmit in progress |
| rx_act | input | 1 | Receive activity present |
| sq_valid | input | 1 | 10 Mb/s squelch reports valid data |
| sig_det | input | 1 | 100 Mb/s signal detect |
| line_bit | input | 1 | 100 Mb/s serial line bit, sampled on `bit_tick` |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision / heartbeat indication |

## Verification
Faults in internal state show up at the ports quickly, though not always on the next clock. A stuck or mis-cleared qualification count moves the `col` rising edge away from the clock after the 7th tick. It can also let a broken-up collision assert early, which the bench sees within a few bit times of the second onset.

A wrong record of which side started first turns an immediate report into a seven-tick delay, or the reverse. That is visible on the first clock after the onset.

A heartbeat sequencer that counts wrongly shifts the pulse edges by whole ticks. One that misses a cancel or a suppression produces a `col` pulse where none is allowed, within twenty ticks.

A carrier lock that forms on adjacent zeros raises `crs` two clocks after the second zero.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    SQE_IDLE  = 2'd0,
    SQE_WAIT  = 2'd1,
    SQE_PULSE = 2'd2
  } sqe_st_e;
endpackage

// File: rtl/mcc_rx_carrier.sv
module mcc_rx_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic speed_100,
  input  logic rx_act,
  input  logic sq_valid,
  input  logic sig_det,
  input  logic line_bit,
  output logic rx_car
);
  logic seen0_q, armed_q, lock_q;
  logic track;

  assign track = rx_act & sig_det;

  // zero, one-or-more ones, zero => lock
  always_ff @(posedge clk) begin
    if (!rst_n || !track) begin
      seen0_q <= 1'b0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else if (bit_tick) begin
      if (!line_bit) begin
        if (armed_q) lock_q <= 1'b1;
        seen0_q <= 1'b1;
        armed_q <= 1'b0;
      end else if (seen0_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign rx_car = rx_act & (speed_100 ? (sig_det & lock_q) : sq_valid);

  // R4
  lock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(armed_q) && !$past(line_bit) && $past(bit_tick)));
endmodule

// File: rtl/mcc_col_qual.sv
module mcc_col_qual #(
  parameter int QUAL_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic speed_100,
  input  logic full_dup,
  input  logic tx_act,
  input  logic rx_car,
  output logic col_coll
);
  localparam int CW = $clog2(QUAL_BITS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_BITS);

  logic          coll, onset, qual_now, qual_eff;
  logic          rx_prev_q, coll_prev_q, qual_q, col_q;
  logic [CW-1:0] cnt_q, cnt_next;

  assign coll     = !full_dup & tx_act & rx_car;
  assign onset    = coll & !coll_prev_q;
  assign qual_now = !speed_100 & !rx_prev_q;
  assign qual_eff = onset ? qual_now : qual_q;

  always_comb begin
    cnt_next = cnt_q;
    if (!coll)
      cnt_next = '0;
    else if (qual_eff && bit_tick && cnt_q != CNT_MAX)
      cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev_q   <= 1'b0;
      coll_prev_q <= 1'b0;
      qual_q      <= 1'b0;
      cnt_q       <= '0;
      col_q       <= 1'b0;
    end else begin
      rx_prev_q   <= rx_car;
      coll_prev_q <= coll;
      qual_q      <= coll & qual_eff;
      cnt_q       <= cnt_next;
      col_q       <= coll & (!qual_eff | (cnt_q == CNT_MAX));
    end
  end

  assign col_coll = col_q;

  // R5
  fdx_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> !col_q);
  // R7
  qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && qual_eff && cnt_q != CNT_MAX) |=> !col_q);
  // R9
  col_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coll |=> !col_q);
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_MAX) && (!coll_prev_q -> cnt_q == '0));
endmodule

// File: rtl/mcc_sqe_gen.sv
module mcc_sqe_gen
  import mcc_pkg::*;
#(
  parameter int GAP_TICKS   = 10,
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic speed_100,
  input  logic full_dup,
  input  logic hb_en,
  input  logic tx_act,
  output logic sqe_pulse
);
  localparam int MAXV = (GAP_TICKS > PULSE_TICKS) ? GAP_TICKS : PULSE_TICKS;
  localparam int TW   = $clog2(MAXV + 1);
  localparam logic [TW-1:0] GAP_LAST   = TW'(GAP_TICKS - 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_TICKS - 1);

  sqe_st_e       st_q, st_n;
  logic [TW-1:0] tk_q, tk_n;
  logic          tx_prev_q, allow;

  assign allow = hb_en & !speed_100 & !full_dup;

  always_comb begin
    st_n = st_q;
    tk_n = tk_q;
    unique case (st_q)
      SQE_IDLE: if (allow && tx_prev_q && !tx_act) begin
        st_n = SQE_WAIT;
        tk_n = '0;
      end
      SQE_WAIT: if (!allow || tx_act) begin
        st_n = SQE_IDLE;
      end else if (bit_tick) begin
        if (tk_q == GAP_LAST) begin
          st_n = SQE_PULSE;
          tk_n = '0;
        end else tk_n = tk_q + 1'b1;
      end
      SQE_PULSE: if (!allow) begin
        st_n = SQE_IDLE;
      end else if (bit_tick) begin
        if (tk_q == PULSE_LAST) st_n = SQE_IDLE;
        else tk_n = tk_q + 1'b1;
      end
      default: st_n = SQE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQE_IDLE;
      tk_q      <= '0;
      tx_prev_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      tk_q      <= tk_n;
      tx_prev_q <= tx_act;
    end
  end

  assign sqe_pulse = (st_q == SQE_PULSE);

  // R11
  sqe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> (st_q == SQE_IDLE));
  // R11
  sqe_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQE_WAIT && tx_act) |=> (st_q == SQE_IDLE));
  // R10
  sqe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_pulse) |-> ($past(st_q) == SQE_WAIT && $past(bit_tick)));
endmodule

// File: rtl/mii_carrier_col.sv
module mii_carrier_col #(
  parameter int QUAL_BITS   = 7,
  parameter int GAP_TICKS   = 10,
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic speed_100,
  input  logic full_dup,
  input  logic hb_en,
  input  logic tx_act,
  input  logic rx_act,
  input  logic sq_valid,
  input  logic sig_det,
  input  logic line_bit,
  output logic crs,
  output logic col
);
  logic rx_car, col_coll, sqe_pulse, crs_q;

  mcc_rx_carrier u_rxc (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
    .rx_act(rx_act), .sq_valid(sq_valid), .sig_det(sig_det),
    .line_bit(line_bit), .rx_car(rx_car)
  );

  mcc_col_qual #(.QUAL_BITS(QUAL_BITS)) u_colq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
    .full_dup(full_dup), .tx_act(tx_act), .rx_car(rx_car),
    .col_coll(col_coll)
  );

  mcc_sqe_gen #(.GAP_TICKS(GAP_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_sqe (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
    .full_dup(full_dup), .hb_en(hb_en), .tx_act(tx_act),
    .sqe_pulse(sqe_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) crs_q <= 1'b0;
    else        crs_q <= full_dup ? rx_car : (rx_car | tx_act);
  end

  assign crs = crs_q;
  assign col = col_coll | sqe_pulse;

  // R1
  hdx_tx_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && tx_act) |=> crs);
  // R2
  fdx_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup && !rx_car) |=> !crs);
endmodule

// File: tb/sim_mii_carrier_col.sv
module sim_mii_carrier_col;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, speed_100 = 1'b0, full_dup = 1'b0, hb_en = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, sq_valid = 1'b0, sig_det = 1'b0, line_bit = 1'b1;
  logic crs, col;
  int   nchk = 0, nerr = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  mii_carrier_col u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .speed_100(speed_100),
    .full_dup(full_dup), .hb_en(hb_en), .tx_act(tx_act), .rx_act(rx_act),
    .sq_valid(sq_valid), .sig_det(sig_det), .line_bit(line_bit),
    .crs(crs), .col(col)
  );

  // {full_dup, speed_100, tx_act, rx_act, sq_valid, exp_crs, exp_col}
  localparam logic [6:0] VECS [0:11] = '{
    7'b00000_00, 7'b00100_10, 7'b10100_00, 7'b10011_10,
    7'b10111_10, 7'b00111_11, 7'b00011_10, 7'b00010_00,
    7'b00000_00, 7'b00100_10, 7'b00111_10, 7'b00000_00
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic tk);
    bit_tick = tk;
    @(posedge clk);
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic lock_seq();
    line_bit = 1'b0; step(1'b1);
    line_bit = 1'b1; step(1'b1);
    line_bit = 1'b0; step(1'b1);
    line_bit = 1'b1;
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    check("reset crs", crs, 1'b0);
    check("reset col", col, 1'b0);
    rst_n = 1'b1;
    step(1'b0);

    // table: R1 R2 R3 R5 R6 R9 at 10 Mb/s, heartbeat off
    foreach (VECS[i]) begin
      {full_dup, speed_100, tx_act, rx_act, sq_valid} = VECS[i][6:2];
      step(1'b0); step(1'b0);
      check($sformatf("vec%0d crs R1/R2/R3", i), crs, VECS[i][1]);
      check($sformatf("vec%0d col R5/R6/R9", i), col, VECS[i][0]);
    end

    // R7: transmit first, then receive -> seven-tick qualification
    tx_act = 1'b1; step(1'b0);
    rx_act = 1'b1; sq_valid = 1'b1;
    t = 0;
    for (int i = 0; i < 30; i++) begin
      logic tk;
      logic ex;
      tk = (i % 3 == 2);
      ex = (t >= 7);
      step(tk);
      check("R7 qualified col", col, ex);
      if (tk) t++;
    end
    // R9: condition ends -> col falls one clock later
    rx_act = 1'b0; step(1'b0);
    check("R9 col release", col, 1'b0);

    // R8: interrupted qualification restarts
    rx_act = 1'b1;
    for (int i = 0; i < 5; i++) begin step(1'b1); step(1'b0); end
    rx_act = 1'b0; step(1'b0);
    rx_act = 1'b1;
    for (int i = 0; i < 6; i++) begin step(1'b1); step(1'b0); end
    check("R8 count restarted", col, 1'b0);
    step(1'b1);
    check("R8 seventh tick edge", col, 1'b0);
    step(1'b0);
    check("R8 col after seven", col, 1'b1);
    tx_act = 1'b0; rx_act = 1'b0; sq_valid = 1'b0;
    step(1'b0); step(1'b0);

    // R4: 100 Mb/s carrier lock
    speed_100 = 1'b1; sig_det = 1'b1; rx_act = 1'b1;
    line_bit = 1'b0; step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    check("R4 adjacent zeros no lock", crs, 1'b0);
    line_bit = 1'b1; step(1'b1);
    line_bit = 1'b0; step(1'b1);
    step(1'b0);
    check("R4 lock formed", crs, 1'b1);
    sig_det = 1'b0; step(1'b0); step(1'b0);
    check("R4 signal detect lost", crs, 1'b0);
    sig_det = 1'b1;
    line_bit = 1'b1; step(1'b1);
    line_bit = 1'b0; step(1'b1);
    step(1'b0); step(1'b0);
    check("R4 one-zero no lock", crs, 1'b0);
    line_bit = 1'b1; step(1'b1);
    line_bit = 1'b0; step(1'b1);
    step(1'b0);
    check("R4 relock", crs, 1'b1);
    rx_act = 1'b0; step(1'b0); step(1'b0);
    check("R4 end of packet", crs, 1'b0);

    // R6: 100 Mb/s transmit-first collision reported at once
    tx_act = 1'b1; step(1'b0);
    rx_act = 1'b1;
    lock_seq();
    step(1'b0);
    check("R6 100M immediate col", col, 1'b1);
    step(1'b0);
    check("R9 col held", col, 1'b1);
    tx_act = 1'b0; rx_act = 1'b0; sig_det = 1'b0;
    step(1'b0); step(1'b0);

    // R10: heartbeat timing
    speed_100 = 1'b0; hb_en = 1'b1;
    tx_act = 1'b1; step(1'b0); step(1'b0);
    tx_act = 1'b0; step(1'b0);
    t = 0;
    for (int i = 0; i < 70; i++) begin
      logic tk;
      tk = (i % 3 == 0);
      step(tk);
      if (tk) t++;
      check("R10 heartbeat", col, (t >= 10 && t < 20));
    end

    // R11: cancelled by a new transmission during the delay
    tx_act = 1'b1; step(1'b0);
    tx_act = 1'b0; step(1'b0);
    for (int i = 0; i < 5; i++) begin step(1'b1); step(1'b0); end
    tx_act = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step(i % 2 == 0);
      check("R11 cancelled heartbeat", col, 1'b0);
    end
    // R11: suppressed at 100 Mb/s
    speed_100 = 1'b1;
    tx_act = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(i % 2 == 0);
      check("R11 100M no heartbeat", col, 1'b0);
    end
    // R11: suppressed with heartbeat disabled
    speed_100 = 1'b0; hb_en = 1'b0;
    tx_act = 1'b1; step(1'b0);
    tx_act = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(i % 2 == 0);
      check("R11 disabled no heartbeat", col, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule